// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block is the command front end of a NOR-style flash model. It watches single-cycle bus writes and recognises a six-write erase protocol: two unlock writes, an erase setup write, two more unlock writes, and a final command. The final command starts either a whole-device erase or a sector erase. The erase itself is stood in for by a cycle counter. The array storage behind the block supplies read data, and the block replaces that data with all ones in any sector it has erased.

A sector erase opens an acceptance window. Further sector-erase writes aimed at the same bank can be queued during the window, in any order, and each accepted write restarts the window. When the window runs out, the queued sectors are erased together. Busy is raised from the first sector command until the erase ends. While busy, reads return a status byte instead of array data. The active-low reset is asynchronous and aborts any window or erase at once.

Top module: `flash_erase_cmd`

## Requirements
- R1: After reset, busy_o is 0, sect_map_o is all zeros, and a read returns array_rdata_i.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 start a device erase. This compares only the low ADDR_W-BANK_W address bits. From the next cycle, busy_o is 1 and every bit of sect_map_o is 1. busy_o falls exactly ERASE_CYC cycles after the final write, and every sector then reads 0xFF.
- R3: The same five leading writes followed by data 0x30 start a sector erase. The top BANK_W address bits give the bank and the next SECT_W bits give the sector. This sets sect_map_o bit (bank*2^SECT_W + sector) and raises busy_o.
- R4: While the window is open, a 0x30 write to the same bank sets that sector's bit, in any order, and restarts the window at WIN_CYC cycles.
- R5: The erase phase starts WIN_CYC cycles after the last accepted sector write. busy_o falls ERASE_CYC cycles after that, and sect_map_o clears. Queued sectors then read 0xFF, and all other sectors read array_rdata_i.
- R6: During the window, a 0x30 write to another bank, or any write whose data is neither 0x30 nor 0xB0, aborts the operation. busy_o and sect_map_o return to 0 the next cycle, and no sector is erased.
- R7: A 0xB0 write during the window is ignored. It leaves sect_map_o unchanged and does not restart the window.
- R8: Writes during the erase phase are ignored. sect_map_o and the completion cycle are unchanged.
- R9: A write that breaks the six-write sequence returns the decoder to idle with no side effect. A later lone final command does nothing, and a complete sequence still works.
- R10: While busy_o is 1, a read returns a byte with bit 7 = 0 and bits 5..0 = 0. Bit 6 inverts on each successive read.
- R11: Asserting rst_ni during an erase drops busy_o and clears sect_map_o without waiting for a clock. The sectors are not marked erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| re_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Bus address: bank, sector, offset |
| wdata_i | input | 8 | Write data |
| array_rdata_i | input | 8 | Read data from the array model |
| rdata_o | output | 8 | Read data or status byte |
| busy_o | output | 1 | 1 while a window or an erase is active |
| sect_map_o | output | 2^(BANK_W+SECT_W) | Sectors selected for the current erase |

## Verification
Some properties are checked by assertions on every cycle:
- The sector map is empty whenever the block is not busy.
- The map only grows while the window is open.
- The map holds still for the whole erase phase.
- The map never spans two banks during a window.
- Status reads carry a zero bit 7 and a bit 6 that flips from one read to the next.

Other behaviour only the directed scenarios can show:
- The exact cycle on which busy falls after retriggered windows.
- That a suspend code does not restart the window.
- That aborted or broken sequences leave no sector erased.
- That an asynchronous reset in mid-erase leaves the array data visible.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  typedef enum logic [1:0] {CTL_READ, CTL_WINDOW, CTL_ERASE} ctl_state_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_UL1, SQ_UL2, SQ_SETUP, SQ_UL3, SQ_UL4} seq_state_e;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_SETUP   = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_SUSPEND = 8'hB0;

  localparam int unsigned KEY_ADDR_A = 32'h555;
  localparam int unsigned KEY_ADDR_B = 32'h2AA;
endpackage

// File: rtl/flash_seq_decoder.sv
`timescale 1ns/1ps
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CMD_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CMD_AW-1:0] cmd_addr_i,
  input  logic [7:0]        data_i,
  output logic              chip_go_o,
  output logic              sect_go_o
);
  seq_state_e sq_q, sq_d;
  logic at_a, at_b;

  assign at_a = (cmd_addr_i == CMD_AW'(KEY_ADDR_A));
  assign at_b = (cmd_addr_i == CMD_AW'(KEY_ADDR_B));

  always_comb begin
    sq_d      = sq_q;
    chip_go_o = 1'b0;
    sect_go_o = 1'b0;
    if (wr_i) begin
      sq_d = SQ_IDLE; // any mismatch falls back to idle
      unique case (sq_q)
        SQ_IDLE:  if (at_a && data_i == CODE_KEY_A) sq_d = SQ_UL1;
        SQ_UL1:   if (at_b && data_i == CODE_KEY_B) sq_d = SQ_UL2;
        SQ_UL2:   if (at_a && data_i == CODE_SETUP) sq_d = SQ_SETUP;
        SQ_SETUP: if (at_a && data_i == CODE_KEY_A) sq_d = SQ_UL3;
        SQ_UL3:   if (at_b && data_i == CODE_KEY_B) sq_d = SQ_UL4;
        SQ_UL4: begin
          chip_go_o = at_a && (data_i == CODE_CHIP);
          sect_go_o = (data_i == CODE_SECTOR);
        end
        default: sq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq_q <= SQ_IDLE;
    else         sq_q <= sq_d;
  end
endmodule

// File: rtl/flash_down_timer.sv
`timescale 1ns/1ps
module flash_down_timer #(
  parameter int unsigned MAX_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(MAX_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !load_i && !clear_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= CW'(MAX_CYC);
    else if (clear_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/flash_sector_map.sv
`timescale 1ns/1ps
module flash_sector_map #(
  parameter int unsigned IDX_W = 5,
  localparam int unsigned NTOT = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_one_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             set_all_i,
  input  logic             clear_i,
  input  logic             commit_i,
  output logic [NTOT-1:0]  map_o,
  output logic [NTOT-1:0]  blank_o
);
  for (genvar i = 0; i < NTOT; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        map_o[i] <= 1'b0;
      else if (clear_i)
        map_o[i] <= 1'b0;
      else if (set_all_i || (set_one_i && set_idx_i == IDX_W'(i)))
        map_o[i] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  blank_o[i] <= 1'b0;
      else if (commit_i && map_o[i]) blank_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_erase_cmd.sv
`timescale 1ns/1ps
module flash_erase_cmd
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned SECT_W    = 4,
  parameter int unsigned WIN_CYC   = 10000,
  parameter int unsigned ERASE_CYC = 4000,
  localparam int unsigned IDX_W    = BANK_W + SECT_W,
  localparam int unsigned NTOT     = 1 << IDX_W,
  localparam int unsigned CMD_AW   = ADDR_W - BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        array_rdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic [NTOT-1:0]   sect_map_o
);
  ctl_state_e ctl_q, ctl_d;
  logic [BANK_W-1:0] bank_sel, win_bank_q;
  logic [IDX_W-1:0]  idx_sel;
  logic chip_go, sect_go, add_sect, abort_win, win_exp, ers_done, tog_q;
  logic [NTOT-1:0] blank;

  assign bank_sel = addr_i[ADDR_W-1 -: BANK_W];
  assign idx_sel  = addr_i[ADDR_W-1 -: IDX_W];

  flash_seq_decoder #(.CMD_AW(CMD_AW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (we_i && ctl_q == CTL_READ),
    .cmd_addr_i (addr_i[CMD_AW-1:0]),
    .data_i     (wdata_i),
    .chip_go_o  (chip_go),
    .sect_go_o  (sect_go)
  );

  // window: same-bank sector codes extend, suspend code is inert, rest aborts
  always_comb begin
    add_sect  = 1'b0;
    abort_win = 1'b0;
    if (ctl_q == CTL_WINDOW && we_i) begin
      if (wdata_i == CODE_SECTOR && bank_sel == win_bank_q) add_sect = 1'b1;
      else if (wdata_i != CODE_SUSPEND)                     abort_win = 1'b1;
    end
  end

  flash_down_timer #(.MAX_CYC(WIN_CYC)) u_win_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sect_go || add_sect),
    .clear_i  (abort_win),
    .run_i    (ctl_q == CTL_WINDOW),
    .expire_o (win_exp)
  );

  flash_down_timer #(.MAX_CYC(ERASE_CYC)) u_ers_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (win_exp || chip_go),
    .clear_i  (1'b0),
    .run_i    (ctl_q == CTL_ERASE),
    .expire_o (ers_done)
  );

  flash_sector_map #(.IDX_W(IDX_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_one_i (sect_go || add_sect),
    .set_idx_i (idx_sel),
    .set_all_i (chip_go),
    .clear_i   (abort_win || ers_done),
    .commit_i  (ers_done),
    .map_o     (sect_map_o),
    .blank_o   (blank)
  );

  always_comb begin
    ctl_d = ctl_q;
    unique case (ctl_q)
      CTL_READ: begin
        if (chip_go)      ctl_d = CTL_ERASE;
        else if (sect_go) ctl_d = CTL_WINDOW;
      end
      CTL_WINDOW: begin
        if (abort_win)    ctl_d = CTL_READ;
        else if (win_exp) ctl_d = CTL_ERASE;
      end
      CTL_ERASE: if (ers_done) ctl_d = CTL_READ;
      default: ctl_d = CTL_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_READ;
      win_bank_q <= '0;
      tog_q      <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      if (sect_go)          win_bank_q <= bank_sel;
      if (re_i && busy_o)   tog_q      <= ~tog_q;
    end
  end

  assign busy_o  = (ctl_q != CTL_READ);
  assign rdata_o = busy_o        ? {1'b0, tog_q, 6'b0} :
                   blank[idx_sel] ? 8'hFF : array_rdata_i;
endmodule

// File: rtl/flash_erase_cmd_chk.sv
`timescale 1ns/1ps
module flash_erase_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int unsigned BANK_W = 1,
  parameter int unsigned SECT_W = 4,
  localparam int unsigned NBANK = 1 << BANK_W,
  localparam int unsigned NSECT = 1 << SECT_W,
  localparam int unsigned NTOT  = NBANK * NSECT
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            re_i,
  input logic            busy_o,
  input logic [7:0]      rdata_o,
  input logic [NTOT-1:0] sect_map_o,
  input ctl_state_e      ctl_i
);
  logic [NBANK-1:0] bank_any;
  always_comb
    for (int b = 0; b < NBANK; b++) bank_any[b] = |sect_map_o[b*NSECT +: NSECT];

  // R1
  idle_map_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sect_map_o == '0);

  // R4
  window_map_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == CTL_WINDOW && $past(ctl_i) == CTL_WINDOW)
      |-> ((sect_map_o & $past(sect_map_o)) == $past(sect_map_o)));

  // R6
  window_one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i == CTL_WINDOW |-> $onehot0(bank_any));

  // R8
  erase_map_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == CTL_ERASE && $past(ctl_i) == CTL_ERASE) |-> $stable(sect_map_o));

  // R10
  status_fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && re_i) |-> (rdata_o[7] == 1'b0 && rdata_o[5:0] == 6'd0));

  // R10
  status_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && re_i) |=> (!busy_o || rdata_o[6] != $past(rdata_o[6])));
endmodule

bind flash_erase_cmd flash_erase_cmd_chk #(.BANK_W(BANK_W), .SECT_W(SECT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .re_i       (re_i),
  .busy_o     (busy_o),
  .rdata_o    (rdata_o),
  .sect_map_o (sect_map_o),
  .ctl_i      (ctl_q)
);

// File: tb/sim_flash_erase_cmd.sv
`timescale 1ns/1ps
module sim_flash_erase_cmd;
  localparam int W  = 200;
  localparam int ER = 120;
  localparam logic [7:0] ARR = 8'h5A;

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        busy;
  logic [31:0] smap;
  int cyc = 0, n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_erase_cmd #(.ADDR_W(12), .BANK_W(1), .SECT_W(4), .WIN_CYC(W), .ERASE_CYC(ER)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .array_rdata_i(ARR), .rdata_o(rdata), .busy_o(busy), .sect_map_o(smap));

  function automatic logic [11:0] sa(input int bank, input int sect);
    return {bank[0], sect[3:0], 7'h13};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1; d = rdata;
    @(posedge clk); #1; re = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic cmd_seq(input logic [11:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    #1;
    check("R1 busy", busy, 0);
    check("R1 map", smap, 0);
    rd(sa(0, 3), d);
    check("R1 read", d, ARR);
  endtask

  task automatic t_chip();
    logic [7:0] s0, s1, d;
    int t0;
    do_reset();
    cmd_seq(12'hD55, 8'h10); // bank bit set: command compare ignores it
    t0 = cyc;
    check("R2 busy", busy, 1);
    check("R2 map", smap, 32'hFFFF_FFFF);
    rd(sa(0, 1), s0);
    rd(sa(0, 1), s1);
    check("R10 bit7", s0[7], 0);
    check("R10 low", {s0[5:0], s1[5:0]}, 0);
    check("R10 toggle", s0[6] ^ s1[6], 1);
    wr(sa(1, 2), 8'h30);
    wr(12'h555, 8'hAA);
    check("R8 map", smap, 32'hFFFF_FFFF);
    wait_until(t0 + ER - 1);
    check("R8 busy before end", busy, 1);
    wait_until(t0 + ER);
    check("R2 busy end", busy, 0);
    rd(sa(0, 3), d);
    check("R2 blank b0", d, 8'hFF);
    rd(sa(1, 15), d);
    check("R2 blank b1", d, 8'hFF);
  endtask

  task automatic t_window();
    logic [7:0] d;
    int t;
    do_reset();
    cmd_seq(sa(0, 5), 8'h30);
    t = cyc;
    check("R3 map", smap, 32'h0000_0020);
    check("R3 busy", busy, 1);
    wait_until(t + W - 2);
    wr(sa(0, 2), 8'h30);
    t = cyc;
    check("R4 add lower", smap, 32'h0000_0024);
    wait_until(t + W - 2);
    wr(sa(0, 9), 8'h30);
    t = cyc;
    check("R4 add again", smap, 32'h0000_0224);
    wait_until(t + W - 4);
    wr(12'h555, 8'hB0);
    check("R7 map", smap, 32'h0000_0224);
    check("R7 busy", busy, 1);
    wait_until(t + W + ER - 1);
    check("R7 no restart busy", busy, 1);
    wait_until(t + W + ER);
    check("R5 busy end", busy, 0);
    check("R5 map cleared", smap, 0);
    rd(sa(0, 5), d); check("R5 s5", d, 8'hFF);
    rd(sa(0, 2), d); check("R5 s2", d, 8'hFF);
    rd(sa(0, 9), d); check("R5 s9", d, 8'hFF);
    rd(sa(0, 4), d); check("R5 s4 kept", d, ARR);
    rd(sa(1, 5), d); check("R5 other bank", d, ARR);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    cmd_seq(sa(0, 1), 8'h30);
    wr(sa(1, 1), 8'h30);
    check("R6 xbank busy", busy, 0);
    check("R6 xbank map", smap, 0);
    cmd_seq(sa(0, 2), 8'h30);
    wr(12'h555, 8'hF0);
    check("R6 other code busy", busy, 0);
    wait_until(cyc + W + ER + 5);
    rd(sa(0, 1), d); check("R6 s1 kept", d, ARR);
    rd(sa(0, 2), d); check("R6 s2 kept", d, ARR);
  endtask

  task automatic t_broken();
    do_reset();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wr(12'h555, 8'h10);
    check("R9 lone final", busy, 0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
    check("R9 bad final busy", busy, 0);
    check("R9 bad final map", smap, 0);
    cmd_seq(12'h555, 8'h10);
    check("R9 recovers", busy, 1);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    int t;
    do_reset();
    cmd_seq(sa(1, 7), 8'h30);
    t = cyc;
    wait_until(t + W + 10);
    check("R11 in erase", busy, 1);
    #1; rst_ni = 1'b0; #1;
    check("R11 busy async", busy, 0);
    check("R11 map async", smap, 0);
    @(negedge clk); rst_ni = 1'b1;
    rd(sa(1, 7), d);
    check("R11 not erased", d, ARR);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_chip();
    t_window();
    t_abort();
    t_broken();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule